// File: doc/BRIEF.md
# Inter-core set/clear mailbox bank

This block holds a bank of 32-bit mailbox registers shared by the cores of a multi-core cluster. With the default parameters there are four cores, and each core owns four mailboxes, so the bank has sixteen. A mailbox is identified by its slot number, which is core × 4 + box.

Any agent can raise bits in a mailbox by writing to that mailbox's set window, and can drop bits by writing to its clear window. Several write ports may act in the same cycle. Each mailbox drives one pending line, which is high whenever the mailbox holds a nonzero value. The pending vector goes to an interrupt router that sits outside this block.

A single read address returns the contents of a mailbox when it points into the clear window. It returns zero anywhere else.

Top module: `mbx_bank`

## Requirements
- R1: Reset (rst_n low, asynchronous) empties every mailbox. After reset every pending bit is 0 and every read returns 0.
- R2: A valid write to byte address 0x80 + 4·s ORs the write data into mailbox s. Here s = core·4 + box, with s from 0 to 15. Bits that were already set stay set.
- R3: A valid write to byte address 0xC0 + 4·s clears, in mailbox s, every bit that is 1 in the write data. The other bits are kept.
- R4: rd_data returns the current contents of mailbox s when rd_addr = 0xC0 + 4·s. The value appears combinationally in the same cycle as the address.
- R5: rd_data is 0 when rd_addr is in the set window (0x80 to 0xBF) or below 0x80.
- R6: pend[s] is 1 exactly when mailbox s is nonzero. A write changes pend in the cycle after it is presented, that is, after the clock edge that stores it.
- R7: When one port sets and another port clears the same mailbox in the same cycle, the clear is applied after the set. The new value is (old | set data) & ~clear data, whichever port does which.
- R8: Sets from several ports to the same mailbox in one cycle are all ORed in. Writes to different mailboxes in one cycle all take effect.
- R9: A valid write to a byte address below 0x80 changes no mailbox.
- R10: A write port whose wr_valid bit is 0 has no effect, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | NUM_PORTS (2) | Write strobe for each port; bit p belongs to port p |
| wr_addr | input | NUM_PORTS·ADDR_W (16) | Byte addresses; port p uses bits [p·8 +: 8] |
| wr_data | input | NUM_PORTS·DATA_W (64) | Write data; port p uses bits [p·32 +: 32] |
| rd_addr | input | ADDR_W (8) | Read byte address |
| rd_data | output | DATA_W (32) | Mailbox contents for an address in the clear window, otherwise 0 |
| pend | output | NUM_MBOX (16) | Bit s is high while mailbox s is nonzero |

## Verification
A set and a clear can hit the same mailbox in the same clock cycle when they arrive on different write ports. The bench provokes this in both port orders. The set data and the clear data overlap on some bits and differ on others. The mailbox read back on the next cycle must equal (old | set) & ~clear, so the overlapping bits must end up cleared. The pending bit is checked at the same point. Two sets landing on one mailbox in the same cycle are also driven, and the result must hold the union of both data words.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Which address window a byte address falls into.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    // Sort an address into the set window, the clear window, or neither.
    function automatic win_e classify(input logic [31:0] a,
                                      input int unsigned set_base,
                                      input int unsigned clr_base,
                                      input int unsigned span);
        if (a >= set_base && a < set_base + span)
            return WIN_SET;
        else if (a >= clr_base && a < clr_base + span)
            return WIN_CLR;
        else
            return WIN_NONE;
    endfunction

    // Word slot of an address counted from the base of its window.
    function automatic int unsigned slot_of(input logic [31:0] a,
                                            input int unsigned base);
        return (a - base) >> 2;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_MBOX = 16,
    parameter int unsigned SET_BASE = 32'h80,
    parameter int unsigned CLR_BASE = 32'hC0
) (
    input  logic                               valid,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  data,
    output logic [NUM_MBOX-1:0][DATA_W-1:0]    set_bits,
    output logic [NUM_MBOX-1:0][DATA_W-1:0]    clr_bits
);

    localparam int unsigned SPAN = NUM_MBOX * 4;

    logic [31:0] a32;
    win_e        win;
    int unsigned slot;

    // Turn one write into a set mask and a clear mask for every mailbox.
    always_comb begin
        a32  = 32'(addr);
        win  = classify(a32, SET_BASE, CLR_BASE, SPAN);
        slot = (win == WIN_CLR) ? slot_of(a32, CLR_BASE) : slot_of(a32, SET_BASE);
        for (int m = 0; m < int'(NUM_MBOX); m++) begin
            set_bits[m] = (valid && win == WIN_SET && slot == int'(m)) ? data : '0;
            clr_bits[m] = (valid && win == WIN_CLR && slot == int'(m)) ? data : '0;
        end
    end

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_MBOX = 16,
    parameter int unsigned SET_BASE = 32'h80,
    parameter int unsigned CLR_BASE = 32'hC0
) (
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic [NUM_MBOX-1:0][DATA_W-1:0]    box,
    output logic [DATA_W-1:0]                  rd_data
);

    localparam int unsigned SPAN = NUM_MBOX * 4;

    logic [31:0] a32;
    win_e        win;
    int unsigned slot;

    // Only the clear window is readable; every other address reads as zero.
    always_comb begin
        a32     = 32'(rd_addr);
        win     = classify(a32, SET_BASE, CLR_BASE, SPAN);
        slot    = slot_of(a32, CLR_BASE);
        rd_data = '0;
        if (win == WIN_CLR) begin
            for (int m = 0; m < int'(NUM_MBOX); m++) begin
                if (slot == int'(m))
                    rd_data = box[m];
            end
        end
    end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CORES     = 4,
    parameter int unsigned BOX_PER_CORE  = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned NUM_PORTS     = 2,
    parameter int unsigned SET_BASE      = 32'h80,
    parameter int unsigned CLR_BASE      = 32'hC0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              wr_valid,
    input  logic [NUM_PORTS*ADDR_W-1:0]       wr_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [NUM_CORES*BOX_PER_CORE-1:0] pend
);

    localparam int unsigned NUM_MBOX = NUM_CORES * BOX_PER_CORE;

    typedef struct packed {
        logic [NUM_MBOX-1:0][DATA_W-1:0] box;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_MBOX-1:0][DATA_W-1:0] box_q;
    logic [NUM_PORTS-1:0][NUM_MBOX-1:0][DATA_W-1:0] set_bits;
    logic [NUM_PORTS-1:0][NUM_MBOX-1:0][DATA_W-1:0] clr_bits;
    logic [NUM_MBOX-1:0][DATA_W-1:0] set_acc;
    logic [NUM_MBOX-1:0][DATA_W-1:0] clr_acc;

    assign box_q = state_q.box;

    // One decoder per write port.
    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .NUM_MBOX (NUM_MBOX),
            .SET_BASE (SET_BASE),
            .CLR_BASE (CLR_BASE)
        ) u_dec (
            .valid    (wr_valid[p]),
            .addr     (wr_addr[p*ADDR_W +: ADDR_W]),
            .data     (wr_data[p*DATA_W +: DATA_W]),
            .set_bits (set_bits[p]),
            .clr_bits (clr_bits[p])
        );
    end

    // Next state: merge all ports, then apply set before clear.
    always_comb begin
        set_acc = '0;
        clr_acc = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            set_acc = set_acc | set_bits[p];
            clr_acc = clr_acc | clr_bits[p];
        end
        state_d = state_q;
        for (int m = 0; m < int'(NUM_MBOX); m++) begin
            state_d.box[m] = (state_q.box[m] | set_acc[m]) & ~clr_acc[m];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    // Pending line for each mailbox, taken from the registered contents.
    for (genvar m = 0; m < int'(NUM_MBOX); m++) begin : g_pend
        assign pend[m] = |box_q[m];
    end

    mbx_read_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_MBOX (NUM_MBOX),
        .SET_BASE (SET_BASE),
        .CLR_BASE (CLR_BASE)
    ) u_rd (
        .rd_addr  (rd_addr),
        .box      (box_q),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NUM_MBOX  = 16,
    parameter int unsigned SET_BASE  = 32'h80,
    parameter int unsigned CLR_BASE  = 32'hC0
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_PORTS-1:0]              wr_valid,
    input logic [NUM_PORTS*ADDR_W-1:0]       wr_addr,
    input logic [NUM_PORTS*DATA_W-1:0]       wr_data,
    input logic [ADDR_W-1:0]                 rd_addr,
    input logic [DATA_W-1:0]                 rd_data,
    input logic [NUM_MBOX-1:0]               pend,
    input logic [NUM_MBOX-1:0][DATA_W-1:0]   box
);

    localparam int unsigned SPAN = NUM_MBOX * 4;

    logic [NUM_PORTS-1:0][NUM_MBOX-1:0] set_hit;
    logic [NUM_PORTS-1:0][NUM_MBOX-1:0] clr_hit;
    logic [NUM_MBOX-1:0]                set_any;
    logic [NUM_MBOX-1:0]                clr_any;
    logic                               rd_in_set;
    logic                               rd_low;
    logic [31:0]                        rd32;

    always_comb begin
        set_hit = '0;
        clr_hit = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            for (int m = 0; m < int'(NUM_MBOX); m++) begin
                set_hit[p][m] = wr_valid[p] &&
                    (32'(wr_addr[p*ADDR_W +: ADDR_W]) == SET_BASE + 4 * m);
                clr_hit[p][m] = wr_valid[p] &&
                    (32'(wr_addr[p*ADDR_W +: ADDR_W]) == CLR_BASE + 4 * m);
            end
        end
        set_any = '0;
        clr_any = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            set_any = set_any | set_hit[p];
            clr_any = clr_any | clr_hit[p];
        end
        rd32      = 32'(rd_addr);
        rd_in_set = rd32 >= SET_BASE && rd32 < SET_BASE + SPAN;
        rd_low    = rd32 < SET_BASE;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0 && box == '0)); // R1

    AST_SET_WINDOW_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_set || rd_low) |-> rd_data == '0); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid == '0) |=> $stable(box)); // R10

    AST_OUTSIDE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_any == '0 && clr_any == '0) |=> $stable(box)); // R9

    for (genvar m = 0; m < int'(NUM_MBOX); m++) begin : g_mb
        AST_READ_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
            (rd32 == CLR_BASE + 4 * m) |-> rd_data == box[m]); // R4
        AST_PEND_AGREES_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (rd32 == CLR_BASE + 4 * m) |-> ((rd_data != '0) == pend[m])); // R6
        for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_pt
            AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
                (set_hit[p][m] && !clr_any[m]) |=>
                ((box[m] & $past(wr_data[p*DATA_W +: DATA_W])) ==
                 $past(wr_data[p*DATA_W +: DATA_W]))); // R2
            AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit[p][m] && !set_any[m]) |=>
                ((box[m] & $past(wr_data[p*DATA_W +: DATA_W])) == '0)); // R3
            AST_CLEAR_OVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit[p][m] && set_any[m]) |=>
                ((box[m] & $past(wr_data[p*DATA_W +: DATA_W])) == '0)); // R7
        end
    end

endmodule

bind mbx_bank mbx_bank_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .NUM_MBOX  (NUM_CORES * BOX_PER_CORE),
    .SET_BASE  (SET_BASE),
    .CLR_BASE  (CLR_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pend     (pend),
    .box      (box_q)
);

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_valid = '0;
    logic [15:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] pend;

    int ran = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbx_bank dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pend     (pend)
    );

    typedef struct packed {
        logic        v0;
        logic [7:0]  a0;
        logic [31:0] d0;
        logic        v1;
        logic [7:0]  a1;
        logic [31:0] d1;
        logic [7:0]  ra;
        logic [31:0] er;
        logic [15:0] ep;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R2: set slot 0
        '{1'b1, 8'h80, 32'h0000_00F1, 1'b0, 8'h00, 32'h0, 8'hC0, 32'h0000_00F1, 16'h0001, 8'd2},
        // R2: OR accumulates
        '{1'b1, 8'h80, 32'h0000_0100, 1'b0, 8'h00, 32'h0, 8'hC0, 32'h0000_01F1, 16'h0001, 8'd2},
        // R6: core 1 box 1 = slot 5, from port 1
        '{1'b0, 8'h00, 32'h0, 1'b1, 8'h94, 32'h8000_0000, 8'hD4, 32'h8000_0000, 16'h0021, 8'd6},
        // R3: partial clear of slot 0
        '{1'b1, 8'hC0, 32'h0000_00F0, 1'b0, 8'h00, 32'h0, 8'hC0, 32'h0000_0101, 16'h0021, 8'd3},
        // R5: set-window read is zero
        '{1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 8'h94, 32'h0, 16'h0021, 8'd5},
        // R9: write below the windows, slot 1 stays empty
        '{1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0, 8'h00, 32'h0, 8'hC4, 32'h0, 16'h0021, 8'd9},
        // R3: full clear of slot 5, pending drops
        '{1'b0, 8'h00, 32'h0, 1'b1, 8'hD4, 32'h8000_0000, 8'hD4, 32'h0, 16'h0001, 8'd3},
        // R8: two sets to slot 15
        '{1'b1, 8'hBC, 32'hA5A5_0000, 1'b1, 8'hBC, 32'h0000_5A5A, 8'hFC, 32'hA5A5_5A5A, 16'h8001, 8'd8},
        // R7: port 0 sets, port 1 clears slot 3
        '{1'b1, 8'h8C, 32'h0000_00FF, 1'b1, 8'hCC, 32'h0000_000F, 8'hCC, 32'h0000_00F0, 16'h8009, 8'd7},
        // R7: port 0 clears, port 1 sets slot 3
        '{1'b1, 8'hCC, 32'h0000_FFFF, 1'b1, 8'h8C, 32'h0000_0300, 8'hCC, 32'h0, 16'h8001, 8'd7},
        // R8: different slots in one cycle
        '{1'b1, 8'hC0, 32'hFFFF_FFFF, 1'b1, 8'hA8, 32'h0000_0001, 8'hE8, 32'h0000_0001, 16'h8400, 8'd8},
        // R5: low address reads zero
        '{1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 8'h00, 32'h0, 16'h8400, 8'd5}
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        ran++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", ran, failed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            ran++;
            failed++;
            $display("FAIL watchdog (all) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state right after reset
        #1;
        check("R1 pend", 32'(pend), 32'h0);
        for (int s = 0; s < 16; s++) begin
            rd_addr = 8'(8'hC0 + 4 * s);
            #0.1;
            check("R1 read", rd_data, 32'h0);
        end

        // Vector table: write for one cycle, then read and check pend.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_valid = {VEC[i].v1, VEC[i].v0};
            wr_addr  = {VEC[i].a1, VEC[i].a0};
            wr_data  = {VEC[i].d1, VEC[i].d0};
            @(posedge clk);
            @(negedge clk);
            wr_valid = '0;
            rd_addr  = VEC[i].ra;
            #1;
            check($sformatf("R%0d read", VEC[i].rq), rd_data, VEC[i].er);
            check($sformatf("R%0d pend", VEC[i].rq), 32'(pend), 32'(VEC[i].ep));
        end

        // R10: an invalid write aimed at slot 0 leaves it empty
        @(negedge clk);
        wr_valid = 2'b00;
        wr_addr  = {8'h80, 8'h80};
        wr_data  = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
        @(posedge clk);
        @(negedge clk);
        rd_addr = 8'hC0;
        #1;
        check("R10 read", rd_data, 32'h0);
        check("R10 pend", 32'(pend), 32'h0000_8400);

        // R6: pending bit 7 changes only after the capturing edge
        @(negedge clk);
        wr_valid = 2'b01;
        wr_addr  = {8'h00, 8'h9C};
        wr_data  = {32'h0, 32'h0000_0040};
        #1;
        check("R6 before edge", 32'(pend[7]), 32'h0);
        @(posedge clk);
        #1;
        check("R6 after edge", 32'(pend[7]), 32'h1);
        rd_addr = 8'hDC;
        #0.1;
        check("R4 read slot 7", rd_data, 32'h0000_0040);
        @(negedge clk);
        wr_valid = '0;

        // R1: reset in the middle of a run empties everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 pend on reset", 32'(pend), 32'h0);
        rd_addr = 8'hFC;
        #0.1;
        check("R1 read on reset", rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_addr = 8'hE8;
        #1;
        check("R1 read after reset", rd_data, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule